// File: doc/BRIEF.md
# Audio Clock Divider Generator

This block derives the three timing signals of a serial audio port from a single module clock: a master-clock phase, a bit-clock phase and a frame (left/right) clock. Each comes with a one-cycle strobe that marks the end of its period. Software chooses the ratios and hands over two small coded fields. One code selects how many module-clock cycles make a master-clock period. The other selects how many master-clock periods make a bit-clock period. Both tables contain ratios that are not powers of two (6, 12, 24), so the block divides with counters and compares, not with shift taps.

The frame clock toggles after a configurable number of bit-clock periods (the word length), so one full frame holds two words. A master-clock enable input gates the whole generator. A controller state machine has three states. `ST_IDLE` holds everything quiet and keeps copying the inputs. `ST_RUN` divides. `ST_FAULT` keeps the master clock running but holds the bit and frame clocks stopped while the bit-clock code is illegal. The transitions are as follows. Idle goes to run, or straight to fault, when the enable rises. Run goes to fault at a frame boundary that samples an illegal code. Fault goes back to run as soon as the code is legal again. Any state returns to idle when the enable drops. While in run, new codes and word lengths are taken only at the frame boundary, so the outputs never carry a runt pulse.

Top module: `aclk_divgen`

## Requirements
- R1: With the enable low, every output (mclk_o, mclk_stb_o, bclk_o, bclk_stb_o, lrclk_o, cfg_err_o) is 0, including the cycles right after reset.
- R2: Master code c (0..7) selects a period of 1, 2, 4, 6, 8, 12, 16 or 24 module clocks. For ratios of 2 and above, mclk_o is high for the first half of each period and low for the second half. mclk_stb_o pulses in the last cycle of each period.
- R3: With master code 0 (ratio 1), mclk_o and mclk_stb_o are both high on every cycle the generator is active.
- R4: Bit code c (0..5) selects a bit period of 2, 4, 6, 8, 12 or 16 master periods. bclk_o is low for the first half and high for the second half. bclk_stb_o pulses only together with mclk_stb_o, in the last master period of a bit.
- R5: lrclk_o starts low and toggles after every word_bits_i bit periods. A word length of 0 means 2^WORD_W bits.
- R6: While running, changes to either code or to the word length take effect only at the frame boundary, which is the bit strobe that drops lrclk_o from high to low. All counters restart there.
- R7: A bit code of 6 or 7 seen when the enable rises, or at a frame boundary, sets cfg_err_o from the next cycle. While cfg_err_o is high, bclk_o, bclk_stb_o and lrclk_o stay low and the master clock keeps running.
- R8: While cfg_err_o is high, a legal bit code clears it on the next cycle. Running then restarts with all counters at zero, using the codes present at that edge.
- R9: Turning on takes one cycle: the first active cycle follows the edge that samples the enable high. Turning off also takes one cycle: every output is 0 on the cycle after the enable is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en_i | input | 1 | Master-clock enable; gates all outputs |
| mdiv_code_i | input | 3 | Coded module-to-master ratio |
| bdiv_code_i | input | 3 | Coded master-to-bit ratio (6 and 7 illegal) |
| word_bits_i | input | WORD_W | Bit periods per half frame (0 = 2^WORD_W) |
| mclk_o | output | 1 | Master-clock phase level |
| mclk_stb_o | output | 1 | Last cycle of a master period |
| bclk_o | output | 1 | Bit-clock phase level |
| bclk_stb_o | output | 1 | Last cycle of a bit period |
| lrclk_o | output | 1 | Frame clock |
| cfg_err_o | output | 1 | Illegal bit code holds the bit clock stopped |

## Verification
If a master-phase counter is off by one, mclk_o and mclk_stb_o drift in the first period, within 24 module clocks. A wrong bit counter shows in bclk_o within one bit period. A wrong word counter or a wrong frame-boundary decision is only visible at the next lrclk_o edge. That can be a whole half frame later, so the bench compares every output on every cycle against a reference that runs through several complete frames after each code change. A controller stuck in the wrong state shows at once on cfg_err_o, or as bclk_o staying quiet.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int CODE_W  = 3;
    localparam int RATIO_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } aclk_state_t;

    // Module clocks per master period.
    function automatic logic [RATIO_W-1:0] mclk_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd0:    r = RATIO_W'(1);
            3'd1:    r = RATIO_W'(2);
            3'd2:    r = RATIO_W'(4);
            3'd3:    r = RATIO_W'(6);
            3'd4:    r = RATIO_W'(8);
            3'd5:    r = RATIO_W'(12);
            3'd6:    r = RATIO_W'(16);
            default: r = RATIO_W'(24);
        endcase
        return r;
    endfunction

    // Master periods per bit period; illegal codes fall back to 2.
    function automatic logic [RATIO_W-1:0] bclk_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd1:    r = RATIO_W'(4);
            3'd2:    r = RATIO_W'(6);
            3'd3:    r = RATIO_W'(8);
            3'd4:    r = RATIO_W'(12);
            3'd5:    r = RATIO_W'(16);
            default: r = RATIO_W'(2);
        endcase
        return r;
    endfunction

    function automatic logic bclk_code_ok(input logic [CODE_W-1:0] code);
        return code < CODE_W'(6);
    endfunction

endpackage

// File: rtl/aclk_phase_div.sv
module aclk_phase_div
    import aclk_pkg::*;
#(
    parameter int CW         = RATIO_W,
    parameter bit HIGH_FIRST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          act_i,
    input  logic          step_i,
    input  logic [CW-1:0] ratio_i,
    output logic          tick_o,
    output logic          level_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half;
    logic          last;

    assign half   = ratio_i >> 1;
    assign last   = (cnt_q == ratio_i - ONE);
    assign tick_o = act_i & step_i & last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (act_i && step_i) begin
            cnt_q <= last ? '0 : cnt_q + ONE;
        end
    end

    generate
        if (HIGH_FIRST) begin : g_high_first
            assign level_o = act_i & ((ratio_i == ONE) | (cnt_q < half));
        end else begin : g_low_first
            assign level_o = act_i & (cnt_q >= half);
        end
    endgenerate

endmodule

// File: rtl/aclk_frame.sv
module aclk_frame #(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              act_i,
    input  logic              step_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              lr_o,
    output logic              frame_end_o
);

    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic [WORD_W-1:0] bit_q;
    logic              lr_q;
    logic              word_done;

    // word_i of 0 wraps to all ones: 2^WORD_W bits per half frame.
    assign word_done   = act_i & step_i & (bit_q == word_i - ONE);
    assign frame_end_o = word_done & lr_q;
    assign lr_o        = act_i & lr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            lr_q  <= 1'b0;
        end else if (clr_i) begin
            bit_q <= '0;
            lr_q  <= 1'b0;
        end else if (act_i && step_i) begin
            bit_q <= word_done ? '0 : bit_q + ONE;
            if (word_done) begin
                lr_q <= ~lr_q;
            end
        end
    end

endmodule

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
    import aclk_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [CODE_W-1:0]  mcode_i,
    input  logic [CODE_W-1:0]  bcode_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               frame_end_i,
    output aclk_state_t        state_o,
    output logic               cnt_clr_o,
    output logic [RATIO_W-1:0] m_ratio_o,
    output logic [RATIO_W-1:0] b_ratio_o,
    output logic [WORD_W-1:0]  word_o
);

    aclk_state_t state_q;
    aclk_state_t state_d;
    logic        load;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) begin
                    state_d = bclk_code_ok(bcode_i) ? ST_RUN : ST_FAULT;
                end
            end
            ST_RUN: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (frame_end_i && !bclk_code_ok(bcode_i)) begin
                    state_d = ST_FAULT;
                end
            end
            ST_FAULT: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (bclk_code_ok(bcode_i)) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Per-state outputs.
    always_comb begin
        load      = 1'b0;
        cnt_clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load      = 1'b1;
                cnt_clr_o = 1'b1;
            end
            ST_RUN: begin
                load = frame_end_i;
            end
            ST_FAULT: begin
                load      = (state_d == ST_RUN);
                cnt_clr_o = (state_d == ST_RUN);
            end
            default: begin
                cnt_clr_o = 1'b1;
            end
        endcase
    end

    // Active configuration, stored already decoded.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ratio_o <= RATIO_W'(1);
            b_ratio_o <= RATIO_W'(2);
            word_o    <= '0;
        end else if (load) begin
            m_ratio_o <= mclk_ratio(mcode_i);
            b_ratio_o <= bclk_ratio(bcode_i);
            word_o    <= word_i;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/aclk_divgen.sv
module aclk_divgen
    import aclk_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclk_en_i,
    input  logic [CODE_W-1:0] mdiv_code_i,
    input  logic [CODE_W-1:0] bdiv_code_i,
    input  logic [WORD_W-1:0] word_bits_i,
    output logic              mclk_o,
    output logic              mclk_stb_o,
    output logic              bclk_o,
    output logic              bclk_stb_o,
    output logic              lrclk_o,
    output logic              cfg_err_o
);

    aclk_state_t        state_s;
    logic               cnt_clr_s;
    logic               run_s;
    logic               act_s;
    logic               frame_end_s;
    logic [RATIO_W-1:0] m_ratio_s;
    logic [RATIO_W-1:0] b_ratio_s;
    logic [WORD_W-1:0]  word_s;

    assign run_s     = (state_s == ST_RUN);
    assign act_s     = (state_s != ST_IDLE);
    assign cfg_err_o = (state_s == ST_FAULT);

    aclk_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mclk_en_i),
        .mcode_i    (mdiv_code_i),
        .bcode_i    (bdiv_code_i),
        .word_i     (word_bits_i),
        .frame_end_i(frame_end_s),
        .state_o    (state_s),
        .cnt_clr_o  (cnt_clr_s),
        .m_ratio_o  (m_ratio_s),
        .b_ratio_o  (b_ratio_s),
        .word_o     (word_s)
    );

    aclk_phase_div #(.CW(RATIO_W), .HIGH_FIRST(1'b1)) u_mdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr_s),
        .act_i  (act_s),
        .step_i (1'b1),
        .ratio_i(m_ratio_s),
        .tick_o (mclk_stb_o),
        .level_o(mclk_o)
    );

    aclk_phase_div #(.CW(RATIO_W), .HIGH_FIRST(1'b0)) u_bdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr_s),
        .act_i  (run_s),
        .step_i (mclk_stb_o),
        .ratio_i(b_ratio_s),
        .tick_o (bclk_stb_o),
        .level_o(bclk_o)
    );

    aclk_frame #(.WORD_W(WORD_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cnt_clr_s),
        .act_i      (run_s),
        .step_i     (bclk_stb_o),
        .word_i     (word_s),
        .lr_o       (lrclk_o),
        .frame_end_o(frame_end_s)
    );

endmodule

// File: rtl/aclk_divgen_chk.sv
module aclk_divgen_chk
    import aclk_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [CODE_W-1:0]  bcode,
    input logic               mclk_o,
    input logic               mclk_stb_o,
    input logic               bclk_o,
    input logic               bclk_stb_o,
    input logic               lrclk_o,
    input logic               cfg_err_o,
    input logic               run,
    input logic               act,
    input logic               frame_end,
    input logic [RATIO_W-1:0] m_ratio,
    input logic [RATIO_W-1:0] b_ratio,
    input logic [WORD_W-1:0]  word
);

    assert_off_after_en_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!mclk_o && !mclk_stb_o && !bclk_o && !lrclk_o && !cfg_err_o));

    assert_ratio_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act && m_ratio == RATIO_W'(1)) |-> (mclk_o && mclk_stb_o));

    assert_bit_on_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb_o |-> mclk_stb_o);

    assert_lr_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && lrclk_o != $past(lrclk_o)) |-> $past(bclk_stb_o));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(frame_end))
            |-> ($stable(m_ratio) && $stable(b_ratio) && $stable(word)));

    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!bclk_o && !bclk_stb_o && !lrclk_o));

    assert_bad_code_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !act && bcode >= CODE_W'(6)) |=> cfg_err_o);

    assert_fault_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && en && bcode < CODE_W'(6)) |=> (!cfg_err_o && !bclk_o && !lrclk_o));

endmodule

bind aclk_divgen aclk_divgen_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (mclk_en_i),
    .bcode     (bdiv_code_i),
    .mclk_o    (mclk_o),
    .mclk_stb_o(mclk_stb_o),
    .bclk_o    (bclk_o),
    .bclk_stb_o(bclk_stb_o),
    .lrclk_o   (lrclk_o),
    .cfg_err_o (cfg_err_o),
    .run       (run_s),
    .act       (act_s),
    .frame_end (frame_end_s),
    .m_ratio   (m_ratio_s),
    .b_ratio   (b_ratio_s),
    .word      (word_s)
);

// File: tb/aclk_divgen_bench.sv
`timescale 1ns/1ps
module aclk_divgen_bench;

    localparam int WORD_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [2:0]        mc = '0;
    logic [2:0]        bc = '0;
    logic [WORD_W-1:0] wb = WORD_W'(4);
    logic mclk_o, mclk_stb_o, bclk_o, bclk_stb_o, lrclk_o, cfg_err_o;

    int    vecs = 0;
    int    errs = 0;
    bit    done = 1'b0;
    string cur  = "R1";

    // reference model state: 0 idle, 1 run, 2 fault
    int m_st = 0, m_mr = 1, m_br = 2, m_wn = 4;
    int m_mc = 0, m_bc = 0, m_bit = 0, m_lr = 0;

    always #2 clk = ~clk;

    aclk_divgen #(.WORD_W(WORD_W)) u_aclk_divgen (
        .clk(clk), .rst_n(rst_n), .mclk_en_i(en),
        .mdiv_code_i(mc), .bdiv_code_i(bc), .word_bits_i(wb),
        .mclk_o(mclk_o), .mclk_stb_o(mclk_stb_o), .bclk_o(bclk_o),
        .bclk_stb_o(bclk_stb_o), .lrclk_o(lrclk_o), .cfg_err_o(cfg_err_o)
    );

    function automatic int mtab(input int c);
        int t[8] = '{1, 2, 4, 6, 8, 12, 16, 24};
        return t[c];
    endfunction

    function automatic int btab(input int c);
        int t[6] = '{2, 4, 6, 8, 12, 16};
        return (c < 6) ? t[c] : 2;
    endfunction

    task automatic load_cfg();
        m_mr = mtab(int'(mc));
        m_br = btab(int'(bc));
        m_wn = (wb == 0) ? (1 << WORD_W) : int'(wb);
    endtask

    task automatic zero();
        m_mc = 0; m_bc = 0; m_bit = 0; m_lr = 0;
    endtask

    task automatic cmp(input string sig, input logic act, input logic exp);
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur, sig, act, exp, $time);
        end
    endtask

    task automatic check_cycle();
        bit act_m, run_m, mstb;
        act_m = (m_st != 0);
        run_m = (m_st == 1);
        mstb  = act_m && (m_mc == m_mr - 1);
        vecs++;
        cmp("mclk_o",     mclk_o,     act_m && (m_mr == 1 || m_mc < m_mr / 2));
        cmp("mclk_stb_o", mclk_stb_o, mstb);
        cmp("bclk_o",     bclk_o,     run_m && (m_bc >= m_br / 2));
        cmp("bclk_stb_o", bclk_stb_o, run_m && mstb && (m_bc == m_br - 1));
        cmp("lrclk_o",    lrclk_o,    run_m && (m_lr == 1));
        cmp("cfg_err_o",  cfg_err_o,  m_st == 2);
    endtask

    task automatic advance();
        bit mstb, bstb, fe;
        mstb = (m_st != 0) && (m_mc == m_mr - 1);
        bstb = (m_st == 1) && mstb && (m_bc == m_br - 1);
        fe   = bstb && (m_bit == m_wn - 1) && (m_lr == 1);
        case (m_st)
            0: begin
                load_cfg(); zero();
                if (en) m_st = (bc < 6) ? 1 : 2;
            end
            1: begin
                if (!en) begin
                    m_st = 0; zero();
                end else begin
                    m_mc = mstb ? 0 : m_mc + 1;
                    if (mstb) m_bc = (m_bc == m_br - 1) ? 0 : m_bc + 1;
                    if (bstb) begin
                        if (m_bit == m_wn - 1) begin
                            m_bit = 0; m_lr = 1 - m_lr;
                        end else begin
                            m_bit++;
                        end
                    end
                    if (fe) begin
                        load_cfg();
                        if (bc >= 6) m_st = 2;
                    end
                end
            end
            default: begin
                if (!en) begin
                    m_st = 0; zero();
                end else if (bc < 6) begin
                    load_cfg(); zero(); m_st = 1;
                end else begin
                    m_mc = mstb ? 0 : m_mc + 1;
                end
            end
        endcase
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            check_cycle();
            advance();
            @(negedge clk);
        end
    endtask

    task automatic restart(input int m, input int b, input int w);
        en = 1'b0;
        run(2);
        mc = 3'(m); bc = 3'(b); wb = WORD_W'(w);
        en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur = "R1";  run(8);                          // quiet with enable low
        cur = "R5";  mc = 3'd1; bc = 3'd0; wb = 6'd4; en = 1'b1; run(200);
        for (int c = 0; c < 8; c++) begin
            cur = (c == 0) ? "R3" : "R2";
            restart(c, 0, 2); run(120);
        end
        for (int c = 0; c < 6; c++) begin
            cur = "R4";
            restart(0, c, 2); run(140);
        end
        cur = "R5";  restart(0, 0, 0); run(600);      // word 0 means 64 bits
        cur = "R6";  restart(1, 0, 3); run(17);
        mc = 3'd3; bc = 3'd1; wb = 6'd5; run(400);    // mid-frame change, deferred
        cur = "R7";  run(9); bc = 3'd6; run(300);     // illegal code at boundary
        cur = "R8";  bc = 3'd2; run(300);
        cur = "R7";  restart(2, 7, 3); run(60);       // illegal code at start
        cur = "R8";  bc = 3'd0; run(60);
        cur = "R9";  run(5); en = 1'b0; run(10);
        en = 1'b1; run(20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired during %s", cur);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule